// File: doc/BRIEF.md
# Fractional-N Pulse-Swallowing Divider

This block divides a fast clock by a fractional ratio. An up-counter normally closes a division after `n` input cycles. At the edge where each division closes, a fractional accumulator adds the word `K` to its residue. If the sum leaves the `N`-bit range, the next division is stretched by one input cycle, so one input cycle is swallowed. Over many divisions the mean output frequency is the input frequency divided by `n + K/2^N`.

The output `div_clk` is a pulse one input cycle wide. It marks the first cycle of each division. The accumulator residue is exported next to it. A later phase-correction stage can use the residue, because at a stretched division it scales with the instantaneous period error.

The integer and fractional settings are sampled only at the edge that opens a division, so a setting can be changed at any time without corrupting the division in progress.

Top module: `fracn_divider`

## Requirements
- R1: While `rst` is high, `div_clk` is 0 and `residue` is 0, and `ratio_int` is loaded. The first `div_clk` pulse appears `n` cycles after the first rising edge with `rst` low.
- R2: With `ratio_frac` = 0, pulses come exactly every `n` cycles and `residue` does not change.
- R3: At each edge that raises `div_clk`, `residue` becomes (previous residue + `ratio_frac`) mod 2^N. In every cycle where `div_clk` is 0, `residue` holds its value.
- R4: A division that opens with an overflowing accumulator update lasts `n`+1 cycles. A division whose update does not overflow lasts `n` cycles.
- R5: With constant settings, 2^N consecutive divisions span exactly `n`·2^N + `K` input cycles.
- R6: `ratio_int` and `ratio_frac` are sampled only at the edge that raises `div_clk`. A change in the middle of a division alters neither that division's length nor `residue`.
- R7: A `ratio_int` value below 2 is treated as 2.
- R8: `div_clk` is high for exactly one input cycle, the first cycle of each division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_int | input | CNT_W | Integer part `n` of the division ratio |
| ratio_frac | input | FRAC_W | Fractional word `K`, in units of 2^-N |
| div_clk | output | 1 | Divided clock, one-cycle pulse per division |
| residue | output | FRAC_W | Accumulator residue after the latest update |

## Verification
A settings reload and an accumulator overflow can both occur at the same division-closing edge. In that case the new division must combine the freshly sampled `n` with the swallowed cycle.

The bench provokes this case by changing `ratio_int` and `ratio_frac` on the last cycle of a division. It picks `K` so that it exactly completes the current residue to 2^N. It then expects a division of new `n`+1 cycles and a residue of zero.

Under randomly timed setting changes, a behavioural model compares pulse and residue on every cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    // Default geometry of the divider
    localparam int unsigned DEF_CNT_W  = 8;
    localparam int unsigned DEF_FRAC_W = 8;
    localparam int unsigned DEF_MIN_N  = 2;

    // Kind of the division currently in progress
    typedef enum logic {
        DIV_BASE    = 1'b0,
        DIV_SWALLOW = 1'b1
    } div_kind_e;

    // Raise a requested integer ratio to the permitted floor
    function automatic int unsigned floor_ratio(input int unsigned req, input int unsigned lo);
        return (req < lo) ? lo : req;
    endfunction

endpackage

// File: rtl/fracn_mod_ctr.sv
module fracn_mod_ctr
    import fracn_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned MIN_N = DEF_MIN_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] n_in,
    input  div_kind_e        kind,
    output logic             wrap,
    output logic [CNT_W:0]   cnt
);
    localparam int unsigned CW = CNT_W + 1;

    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    last_c;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] n_next;

    // Floor-clamped integer ratio, sampled only at a boundary
    always_comb n_next = CNT_W'(floor_ratio(32'(n_in), MIN_N));

    // Terminal count: n, plus one when this division swallows a cycle
    always_comb begin
        last_c = {1'b0, n_q} + {{CNT_W{1'b0}}, (kind == DIV_SWALLOW)} - CW'(1);
        wrap   = (cnt_q == last_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            n_q   <= n_next;
        end else if (wrap) begin
            cnt_q <= '0;
            n_q   <= n_next;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/fracn_sigma_acc.sv
module fracn_sigma_acc
    import fracn_pkg::*;
#(
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [FRAC_W-1:0] k_in,
    output logic [FRAC_W-1:0] acc,
    output div_kind_e         kind
);
    logic [FRAC_W-1:0] acc_q;
    div_kind_e         kind_q;
    logic [FRAC_W:0]   sum_c;

    always_comb sum_c = {1'b0, acc_q} + {1'b0, k_in};

    // Residue and registered overflow, both updated once per division
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            kind_q <= DIV_BASE;
        end else if (step) begin
            acc_q  <= sum_c[FRAC_W-1:0];
            kind_q <= sum_c[FRAC_W] ? DIV_SWALLOW : DIV_BASE;
        end
    end

    assign acc  = acc_q;
    assign kind = kind_q;

    AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst)
        step |=> ((kind_q == DIV_SWALLOW) == (acc_q < $past(acc_q)))); // R4

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned MIN_N  = DEF_MIN_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  ratio_int,
    input  logic [FRAC_W-1:0] ratio_frac,
    output logic              div_clk,
    output logic [FRAC_W-1:0] residue
);
    logic       wrap;
    logic [CNT_W:0] cnt;
    div_kind_e  kind;
    logic       div_q;

    fracn_mod_ctr #(.CNT_W(CNT_W), .MIN_N(MIN_N)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .n_in (ratio_int),
        .kind (kind),
        .wrap (wrap),
        .cnt  (cnt)
    );

    fracn_sigma_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .step (wrap),
        .k_in (ratio_frac),
        .acc  (residue),
        .kind (kind)
    );

    // Divided output: one pulse in the first cycle of each division
    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= wrap;
    end

    assign div_clk = div_q;

    AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (rst)
        div_q |-> (cnt == '0)); // R8

    AST_NO_SHORT_DIV: assert property (@(posedge clk) disable iff (rst)
        div_q |=> !div_q); // R7

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !div_q |-> $stable(residue)); // R3

    AST_ZERO_K: assert property (@(posedge clk) disable iff (rst)
        (wrap && (ratio_frac == '0)) |=> (kind == DIV_BASE)); // R2

endmodule

// File: tb/sim_fracn_divider.sv
`timescale 1ns/1ps
module sim_fracn_divider;
    localparam int CW  = 8;
    localparam int FW  = 8;
    localparam int MOD = 1 << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] n_in = CW'(4);
    logic [FW-1:0] k_in = '0;
    logic          div_clk;
    logic [FW-1:0] residue;

    int    compared   = 0;
    int    mismatched = 0;
    bit    done       = 0;
    string phase_tag  = "R1";

    // Behavioural reference state
    int m_pos, m_len, m_acc;
    bit m_pulse;

    always #2 clk = ~clk;

    fracn_divider #(.CNT_W(CW), .FRAC_W(FW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .ratio_int  (n_in),
        .ratio_frac (k_in),
        .div_clk    (div_clk),
        .residue    (residue)
    );

    function automatic int clampn(int v);
        return (v < 2) ? 2 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_len = clampn(int'(n_in)); m_acc = 0; m_pulse = 0;
        end else if (m_pos + 1 == m_len) begin
            int s;
            s       = m_acc + int'(k_in);
            m_len   = clampn(int'(n_in)) + ((s >= MOD) ? 1 : 0);
            m_acc   = s % MOD;
            m_pos   = 0;
            m_pulse = 1;
        end else begin
            m_pos   = m_pos + 1;
            m_pulse = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({phase_tag, " model pulse"}, int'(div_clk), int'(m_pulse));
            chk({phase_tag, " model residue"}, int'(residue), m_acc);
        end
    end

    task automatic next_pulse(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (div_clk !== 1'b1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int p, tot, r;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset div_clk", int'(div_clk), 0);
        chk("R1 reset residue", int'(residue), 0);
        rst = 1'b0;
        next_pulse(p);
        chk("R1 first pulse distance", p, 4);

        // R2: exact integer division with K = 0
        phase_tag = "R2";
        for (int i = 0; i < 5; i++) begin
            next_pulse(p);
            chk("R2 period", p, 4);
            chk("R2 residue", int'(residue), 0);
        end

        // R7 and R6: ratio below 2 is raised to 2, applied at the next boundary
        phase_tag = "R7";
        n_in = CW'(1);
        next_pulse(p);
        chk("R6 old ratio kept", p, 4);
        next_pulse(p);
        chk("R7 n=1 clamped", p, 2);
        n_in = CW'(0);
        next_pulse(p);
        chk("R7 n=1 clamped again", p, 2);
        next_pulse(p);
        chk("R7 n=0 clamped", p, 2);
        @(negedge clk);
        chk("R8 pulse one cycle wide", int'(div_clk), 0);
        next_pulse(p);

        // R6: mid-division changes have no effect on the running division
        phase_tag = "R6";
        n_in = CW'(6);
        next_pulse(p);
        chk("R6 period before reload", p, 2);
        repeat (2) @(negedge clk);
        n_in = CW'(3);
        k_in = FW'(200);
        chk("R6 residue untouched mid-division", int'(residue), 0);
        next_pulse(p);
        chk("R6 division length kept", p + 2, 6);
        chk("R3 residue after update", int'(residue), 200);

        // R4: overflow stretches the following division
        phase_tag = "R4";
        next_pulse(p);
        chk("R4 no-carry period", p, 3);
        chk("R3 wrapped residue", int'(residue), 144);
        next_pulse(p);
        chk("R4 carry period", p, 4);

        // Reload and carry on the same boundary edge
        phase_tag = "R4 R6";
        n_in = CW'(5);
        k_in = '0;
        next_pulse(p);
        r = int'(residue);
        chk("R2 residue held with K=0", r, 88);
        repeat (4) @(negedge clk);
        n_in = CW'(7);
        k_in = FW'(MOD - r);
        next_pulse(p);
        chk("R6 length of old division", p + 4, 5);
        chk("R3 residue completes to zero", int'(residue), 0);
        next_pulse(p);
        chk("R4 new ratio plus swallow", p, 8);

        // R5: mean ratio over 2^N divisions
        phase_tag = "R5";
        n_in = CW'(3);
        k_in = FW'(37);
        next_pulse(p);
        tot = 0;
        for (int i = 0; i < MOD; i++) begin
            next_pulse(p);
            tot += p;
        end
        chk("R5 span n=3 K=37", tot, 3 * MOD + 37);
        n_in = CW'(10);
        k_in = FW'(255);
        next_pulse(p);
        tot = 0;
        for (int i = 0; i < MOD; i++) begin
            next_pulse(p);
            tot += p;
        end
        chk("R5 span n=10 K=255", tot, 10 * MOD + 255);

        // Randomly timed setting changes judged by the model every cycle
        phase_tag = "R3 R4 R6 R7 R8";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 9) == 0) begin
                n_in = CW'($urandom_range(0, 12));
                k_in = FW'($urandom);
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule